// File: doc/BRIEF.md
# Closed Caption Line Inserter

The block places one closed-caption code pair into the vertical blanking interval of an interlaced video signal. Software loads a word of two 7-bit characters with a ready flag. The block compares the incoming field id, line count and pixel count with its programmed targets. When all three match, it emits a serial frame on a single data-level output. The frame is a clock run-in, a start code, then the two characters, each followed by a parity bit.

When a frame ends, the block drops the ready flag if the word it sent is still the last one written. Software can then load the next pair. If no word is ready on the target line, the block sends a pair of null characters so the caption line keeps its timing. A later stage turns the data level into analog amplitudes.

Top module: `cc_inserter`

## Requirements
- R1: After reset, `rdy_o`, `active_o` and `data_o` are all 0.
- R2: While `enable_i` is 0, no frame starts, and `rdy_o` keeps its value.
- R3: A frame starts only in the field whose id `field_i` equals `field_sel_i`. A line in the other field produces no output.
- R4: A frame starts only when `line_i` equals the 6-bit `line_sel_i`, zero-extended.
- R5: `active_o` rises, and the first bit appears on `data_o`, one clock after the cycle in which `pixel_i` equals `hstart_i`.
- R6: Frame bit order is fixed, and each bit is listed in the order it is sent:
  - the run-in 1,0,1,0,1,0,1;
  - the start code 0,0,1;
  - the 7 bits of `wr_char0_i`, LSB first, then its odd-parity bit;
  - the 7 bits of `wr_char1_i`, LSB first, then its odd-parity bit.
- R7: Each frame bit is held for `BIT_CLKS` clocks, so `active_o` stays high for exactly 26×`BIT_CLKS` clocks.
- R8: At the end of a frame that carried a ready word, `rdy_o` goes to 0 one clock after `active_o` falls, provided no write happened since the frame began.
- R9: If `rdy_o` is 0 when the frame starts, both characters are sent as 0x00, each with parity bit 1, and `rdy_o` stays 0.
- R10: A write during a frame changes neither the remaining bits of that frame nor the written `wr_ready_i` value. That value still shows on `rdy_o` after the frame ends, and the written word is sent on the next matching line.
- R11: `data_o` is 0 whenever `active_o` is 0.
- R12: A write (`wr_i`=1) sets `rdy_o` to `wr_ready_i` on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Caption insertion enable |
| field_sel_i | input | 1 | Field id that carries the caption |
| line_sel_i | input | 6 | Target line number |
| hstart_i | input | 10 | Pixel count at which the frame begins |
| field_i | input | 1 | Current field id |
| line_i | input | LINE_W | Current line count |
| pixel_i | input | PIX_W | Current pixel count |
| wr_i | input | 1 | Data word write strobe |
| wr_char0_i | input | 7 | First character, sent first |
| wr_char1_i | input | 7 | Second character |
| wr_ready_i | input | 1 | Ready flag written with the word |
| rdy_o | output | 1 | Ready flag readback |
| active_o | output | 1 | Frame in progress |
| data_o | output | 1 | Serial caption data level |

## Verification
The bench probes lines that miss only on the field, only on the line, or only on the enable. A design that checked just one of these would emit a frame on the wrong line. The first active pixel and the frame length are checked on every line, so an off-by-one in the start compare or in the per-bit counter shows up at once.

Character patterns with even and odd numbers of set bits, including all ones, expose a parity of the wrong sense. Null insertion after consumption catches a design that resends stale data. A mid-frame write catches a design that shifts out live register data, and also one that clears a freshly written ready flag.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int CHAR_W     = 7;
  localparam int RUNIN_BITS = 7;
  localparam int START_BITS = 3;
  localparam int FRAME_BITS = RUNIN_BITS + START_BITS + 2 * (CHAR_W + 1);

  typedef struct packed {
    logic [CHAR_W-1:0] c1;
    logic [CHAR_W-1:0] c0;
  } cc_word_t;

  // bit 0 of the result is sent first
  function automatic logic [FRAME_BITS-1:0] build_frame(cc_word_t w);
    logic [FRAME_BITS-1:0] f;
    f = '0;
    for (int i = 0; i < RUNIN_BITS; i++) f[i] = (i % 2 == 0);
    f[RUNIN_BITS]   = 1'b0;
    f[RUNIN_BITS+1] = 1'b0;
    f[RUNIN_BITS+2] = 1'b1;
    for (int i = 0; i < CHAR_W; i++) begin
      f[RUNIN_BITS+START_BITS+i]          = w.c0[i];
      f[RUNIN_BITS+START_BITS+CHAR_W+1+i] = w.c1[i];
    end
    f[RUNIN_BITS+START_BITS+CHAR_W]       = ~^w.c0;
    f[RUNIN_BITS+START_BITS+2*CHAR_W+1]   = ~^w.c1;
    return f;
  endfunction
endpackage

// File: rtl/cc_match.sv
module cc_match #(
  parameter int LINE_W = 10,
  parameter int PIX_W  = 12
) (
  input  logic              enable_i,
  input  logic              field_sel_i,
  input  logic [5:0]        line_sel_i,
  input  logic [9:0]        hstart_i,
  input  logic              field_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [PIX_W-1:0]  pixel_i,
  input  logic              busy_i,
  output logic              start_o
);
  logic hit;
  always_comb begin
    hit = (field_i == field_sel_i) &&
          (line_i  == LINE_W'(line_sel_i)) &&
          (pixel_i == PIX_W'(hstart_i));
    start_o = enable_i && hit && !busy_i;
  end
endmodule

// File: rtl/cc_word_reg.sv
module cc_word_reg
  import cc_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wr_i,
  input  cc_word_t wr_word_i,
  input  logic     wr_ready_i,
  input  logic     start_i,
  input  logic     done_i,
  output cc_word_t word_o,
  output logic     rdy_o
);
  logic dirty_q;  // written since the last frame start

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o  <= '0;
      rdy_o   <= 1'b0;
      dirty_q <= 1'b0;
    end else if (wr_i) begin
      word_o  <= wr_word_i;
      rdy_o   <= wr_ready_i;
      dirty_q <= 1'b1;
    end else begin
      if (start_i) dirty_q <= 1'b0;
      if (done_i && !dirty_q) rdy_o <= 1'b0;
    end
  end

  // R12
  wr_rdy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (rdy_o == $past(wr_ready_i)));
endmodule

// File: rtl/cc_serializer.sv
module cc_serializer
  import cc_pkg::*;
#(
  parameter int BIT_CLKS = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [FRAME_BITS-1:0] frame_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  data_o
);
  localparam int SUB_W = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;
  localparam int IDX_W = $clog2(FRAME_BITS);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(BIT_CLKS - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BITS - 1);

  logic [FRAME_BITS-1:0] sh_q;
  logic [SUB_W-1:0]      sub_q;
  logic [IDX_W-1:0]      idx_q;
  logic                  bit_end, last_bit;

  assign bit_end  = (sub_q == SUB_LAST);
  assign last_bit = (idx_q == IDX_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      sub_q  <= '0;
      idx_q  <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        sh_q   <= frame_i;
        sub_q  <= '0;
        idx_q  <= '0;
        busy_o <= 1'b1;
      end else if (busy_o) begin
        if (bit_end) begin
          sub_q <= '0;
          if (last_bit) begin
            busy_o <= 1'b0;
            done_o <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
            sh_q  <= sh_q >> 1;
          end
        end else begin
          sub_q <= sub_q + 1'b1;
        end
      end
    end
  end

  assign data_o = busy_o & sh_q[0];

  // R6
  runin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && idx_q < IDX_W'(RUNIN_BITS)) |-> (data_o == ~idx_q[0]));
  // R6
  start_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && idx_q == IDX_W'(RUNIN_BITS + 2)) |-> data_o);
endmodule

// File: rtl/cc_inserter.sv
module cc_inserter
  import cc_pkg::*;
#(
  parameter int LINE_W   = 10,
  parameter int PIX_W    = 12,
  parameter int BIT_CLKS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              field_sel_i,
  input  logic [5:0]        line_sel_i,
  input  logic [9:0]        hstart_i,
  input  logic              field_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [PIX_W-1:0]  pixel_i,
  input  logic              wr_i,
  input  logic [6:0]        wr_char0_i,
  input  logic [6:0]        wr_char1_i,
  input  logic              wr_ready_i,
  output logic              rdy_o,
  output logic              active_o,
  output logic              data_o
);
  localparam int TOTAL_CLKS = FRAME_BITS * BIT_CLKS;

  logic     start, done;
  cc_word_t word, wr_word, tx_word;

  assign wr_word = '{c1: wr_char1_i, c0: wr_char0_i};
  assign tx_word = rdy_o ? word : '0;  // nulls when nothing is ready

  cc_match #(.LINE_W(LINE_W), .PIX_W(PIX_W)) u_match (
    .enable_i    (enable_i),
    .field_sel_i (field_sel_i),
    .line_sel_i  (line_sel_i),
    .hstart_i    (hstart_i),
    .field_i     (field_i),
    .line_i      (line_i),
    .pixel_i     (pixel_i),
    .busy_i      (active_o),
    .start_o     (start)
  );

  cc_word_reg u_word (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_i),
    .wr_word_i  (wr_word),
    .wr_ready_i (wr_ready_i),
    .start_i    (start),
    .done_i     (done),
    .word_o     (word),
    .rdy_o      (rdy_o)
  );

  cc_serializer #(.BIT_CLKS(BIT_CLKS)) u_ser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .frame_i (build_frame(tx_word)),
    .busy_o  (active_o),
    .done_o  (done),
    .data_o  (data_o)
  );

  // checker-side length counter
  logic [$clog2(TOTAL_CLKS+2)-1:0] act_len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       act_len_q <= '0;
    else if (active_o) act_len_q <= act_len_q + 1'b1;
    else               act_len_q <= '0;
  end

  // R7
  len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_len_q <= TOTAL_CLKS);
  // R5
  start_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> $past(pixel_i == PIX_W'(hstart_i) &&
                              line_i == LINE_W'(line_sel_i) &&
                              field_i == field_sel_i));
  // R2
  disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !$rose(active_o));
  // R11
  idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> !data_o);
endmodule

// File: tb/cc_inserter_tb.sv
module cc_inserter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LINE_W     = 10;
  localparam int PIX_W      = 12;
  localparam int BIT_CLKS   = 4;
  localparam int LINE_PIX   = 160;
  localparam int FRAME_CLKS = 26 * BIT_CLKS;

  logic clk = 0, rst_n = 0;
  logic enable = 0, field_sel = 0, field = 0;
  logic [5:0] line_sel = 6'd21;
  logic [9:0] hstart = 10'd20;
  logic [LINE_W-1:0] line = '0;
  logic [PIX_W-1:0] pixel = '0;
  logic wr = 0, wr_ready = 0;
  logic [6:0] ch0 = '0, ch1 = '0;
  logic rdy, active, data;

  int tests = 0, fails = 0;
  logic exp_q[$];
  int act_cnt, first_pix;

  always #(CLK_PERIOD/2) clk = ~clk;

  cc_inserter #(.LINE_W(LINE_W), .PIX_W(PIX_W), .BIT_CLKS(BIT_CLKS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .field_sel_i(field_sel),
    .line_sel_i(line_sel), .hstart_i(hstart), .field_i(field), .line_i(line),
    .pixel_i(pixel), .wr_i(wr), .wr_char0_i(ch0), .wr_char1_i(ch1),
    .wr_ready_i(wr_ready), .rdy_o(rdy), .active_o(active), .data_o(data)
  );

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: pop and compare every active cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (active) begin
        if (act_cnt == 0) first_pix = pixel;
        act_cnt++;
        if (exp_q.size() == 0) check("R6 extra bit", 1, 0);
        else check("R6 frame bit", data, exp_q.pop_front());
      end else if (data) begin
        check("R11 data idle", data, 0);
      end
    end
  end

  task automatic push_bit(logic b);
    for (int k = 0; k < BIT_CLKS; k++) exp_q.push_back(b);
  endtask

  task automatic push_frame(logic [6:0] c0, logic [6:0] c1);
    for (int i = 0; i < 7; i++) push_bit(i % 2 == 0);
    push_bit(0); push_bit(0); push_bit(1);
    for (int i = 0; i < 7; i++) push_bit(c0[i]);
    push_bit(~^c0);
    for (int i = 0; i < 7; i++) push_bit(c1[i]);
    push_bit(~^c1);
  endtask

  task automatic write_word(logic [6:0] c0, logic [6:0] c1, logic r);
    @(posedge clk); #1;
    wr = 1; ch0 = c0; ch1 = c1; wr_ready = r;
    @(posedge clk); #1;
    wr = 0;
  endtask

  // drive one line; optional mid-line write at pixel wr_pix
  task automatic run_line(logic fld, int ln, bit expect_frame, string req,
                          int wr_pix, logic [6:0] w0, logic [6:0] w1);
    act_cnt = 0;
    first_pix = -1;
    field = fld;
    line = LINE_W'(ln);
    for (int p = 0; p < LINE_PIX; p++) begin
      @(posedge clk); #1;
      pixel = PIX_W'(p);
      wr = (p == wr_pix);
      if (p == wr_pix) begin ch0 = w0; ch1 = w1; wr_ready = 1; end
    end
    @(posedge clk); #1;
    wr = 0;
    pixel = PIX_W'(LINE_PIX);
    @(negedge clk);
    check({req, " active length"}, act_cnt, expect_frame ? FRAME_CLKS : 0);
    if (expect_frame) check("R5 first active pixel", first_pix, hstart + 1);
    check({req, " leftover bits"}, exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check("watchdog", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    check("R1 rdy", rdy, 0);
    check("R1 active", active, 0);
    check("R1 data", data, 0);
    #1 rst_n = 1;

    write_word(7'h41, 7'h62, 1);
    @(negedge clk);
    check("R12 rdy after write", rdy, 1);

    enable = 1;
    run_line(0, 20, 0, "R4", -1, 0, 0);           // R4 wrong line
    run_line(1, 21, 0, "R3", -1, 0, 0);           // R3 wrong field
    enable = 0;
    run_line(0, 21, 0, "R2", -1, 0, 0);           // R2 disabled
    check("R2 rdy kept", rdy, 1);
    enable = 1;

    push_frame(7'h41, 7'h62);                     // R6 R7
    run_line(0, 21, 1, "R7", -1, 0, 0);
    check("R8 rdy cleared", rdy, 0);

    push_frame(7'h00, 7'h00);                     // R9 nulls
    run_line(0, 21, 1, "R9", -1, 0, 0);
    check("R9 rdy stays 0", rdy, 0);

    field_sel = 1;
    write_word(7'h7F, 7'h00, 1);
    push_frame(7'h7F, 7'h00);                     // R10 mid-frame write
    run_line(1, 21, 1, "R10", 60, 7'h11, 7'h22);
    check("R10 new rdy kept", rdy, 1);
    push_frame(7'h11, 7'h22);
    run_line(1, 21, 1, "R10 next", -1, 0, 0);
    check("R8 rdy cleared 2", rdy, 0);
    run_line(0, 21, 0, "R3 sel1", -1, 0, 0);      // R3 field 0 now ignored

    hstart = 10'd3;
    line_sel = 6'd5;
    write_word(7'h55, 7'h2A, 1);
    push_frame(7'h55, 7'h2A);                     // R4 R5 new targets
    run_line(1, 5, 1, "R5", -1, 0, 0);
    check("R8 rdy cleared 3", rdy, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule